// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a 4,608-bit synchronous memory with a separate write port and read port, each on its own clock. Every port chooses its own data width from five aspect codes (1, 2, 4, 9 or 18 bits per word). Both ports address the same physical array, so a word written at one width can be read back at another. A narrow serial stream can be gathered into wide words this way, or a wide word can be split back into narrow pieces.

The physical array holds 512 rows of 9 bits. Bit 8 of each row is a parity-style extra bit, and only the 9- and 18-bit widths can reach it. The 1-, 2- and 4-bit widths work only on the low byte of each row. A port takes a new width code only while it is idle. A flag reports when the two ports are set to widths that cannot share the array.

Top module: `mixw_dpram`

## Requirements
- R1: In ×18 mode the memory holds 256 words of 18 bits. A word written there reads back unchanged through a ×18 read.
- R2: Width codes are 0 = ×1 (address bits [11:0]), 1 = ×2 (bits [10:0]), 2 = ×4 (bits [9:0]), 3 = ×9 (bits [8:0]) and 4 = ×18 (bits [7:0]). Address bits above the used range are ignored. Codes 5, 6 and 7 are invalid.
- R3: The physical array has 512 rows of 9 bits.
  - A ×9 address selects one row directly.
  - ×18 address a holds data[8:0] in row 2a and data[17:9] in row 2a+1.
  - In ×1, ×2 and ×4 modes the row is the address shifted right by 3, 2 or 1 bits. The remaining low bits pick a slice of row bits [7:0], with slice 0 at the least significant end.
- R4: A ×1, ×2 or ×4 write never changes bit 8 of a row. A narrow read never returns bit 8.
- R5: Read data appears on rd_data one rd_clk edge after the edge that samples rd_en high. Bits above the read width are zero.
- R6: While rd_en is low, rd_data keeps its value.
- R7: When a read and a write hit the same location at the same clock edge, the read returns the data stored before that write.
- R8: A port samples its width code only at a clock edge where its enable is low. The new width applies from the next edge. A code presented together with a rising enable is not used for that access.
- R9: aspect_clash goes high when the sampled widths mix the {×9, ×18} class with the {×1, ×2, ×4} class, or when either sampled code is invalid.
  - While aspect_clash is high, every read returns zero.
  - Writes with a valid code are still stored.
- R10: A write whose sampled width code is invalid changes no stored bit.
- R11: After reset, rd_data is zero, both sampled widths are ×18 and aspect_clash is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_en | input | 1 | Write enable |
| wr_aspect | input | 3 | Write width code, sampled while wr_en is low |
| wr_addr | input | 12 | Write address at the write width |
| wr_data | input | 18 | Write data, right-aligned |
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_en | input | 1 | Read enable |
| rd_aspect | input | 3 | Read width code, sampled while rd_en is low |
| rd_addr | input | 12 | Read address at the read width |
| rd_data | output | 18 | Registered read data, zero-extended |
| aspect_clash | output | 1 | The two sampled widths cannot share the array |

## Verification
The assertions check the following on every clock:
- read data holds while rd_en is low;
- reads under a width clash return zero;
- the bits above the read width are zero;
- a narrow or ×9 write enables exactly one bank;
- a narrow write never enables the parity bit;
- an invalid write code enables nothing;
- width codes stay steady while their port is enabled.

The bench compares the ports every cycle against a behavioural model of a flat 4,608-bit array. Only that comparison can show the rest:
- the bit mapping between widths;
- read-before-write on a collision;
- which edge picks up a new width code;
- that the parity bit survives narrow writes.

// File: rtl/mixw_pkg.sv
package mixw_pkg;

    // Width codes shared by both ports
    localparam logic [2:0] ASP_X1  = 3'd0;
    localparam logic [2:0] ASP_X2  = 3'd1;
    localparam logic [2:0] ASP_X4  = 3'd2;
    localparam logic [2:0] ASP_X9  = 3'd3;
    localparam logic [2:0] ASP_X18 = 3'd4;

    function automatic logic asp_valid(input logic [2:0] code);
        return code <= ASP_X18;
    endfunction

    // Wide class reaches the ninth (parity) bit of a row
    function automatic logic asp_wide(input logic [2:0] code);
        return (code == ASP_X9) || (code == ASP_X18);
    endfunction

    function automatic logic asp_narrow(input logic [2:0] code);
        return code <= ASP_X4;
    endfunction

    // Two sampled codes cannot share the array
    function automatic logic asp_clash(input logic [2:0] wcode, input logic [2:0] rcode);
        return !asp_valid(wcode) || !asp_valid(rcode) || (asp_wide(wcode) != asp_wide(rcode));
    endfunction

endpackage

// File: rtl/mixw_bank.sv
module mixw_bank #(
    parameter int DEPTH = 256,
    parameter int ROW_W = 9,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ROW_W-1:0] wmask,
    input  logic [ROW_W-1:0] wdat,
    input  logic [IDX_W-1:0] ridx,
    output logic [ROW_W-1:0] rraw
);

    logic [ROW_W-1:0] mem [DEPTH];
    logic [ROW_W-1:0] merge_d;

    // Per-bit write enable: unmasked bits keep the stored value
    always_comb begin
        merge_d = (mem[widx] & ~wmask) | (wdat & wmask);
    end

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[widx] <= merge_d;
        end
    end

    assign rraw = mem[ridx];

endmodule

// File: rtl/mixw_wlane.sv
module mixw_wlane
    import mixw_pkg::*;
#(
    parameter int ROWS   = 512,
    parameter int ROW_W  = 9,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 18,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int IDX_W  = ROW_AW - 1
) (
    input  logic                  en,
    input  logic [2:0]            aspect,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    output logic [1:0]            we,
    output logic [IDX_W-1:0]      idx,
    output logic [1:0][ROW_W-1:0] mask,
    output logic [1:0][ROW_W-1:0] wdat
);

    localparam int BYTE_W = ROW_W - 1;
    localparam int SEL_W  = $clog2(BYTE_W);

    logic [ROW_AW-1:0] row_c;
    logic [SEL_W-1:0]  slot_c;
    logic [SEL_W-1:0]  pos_c;
    logic [1:0]        k_c;
    logic [BYTE_W-1:0] fld_c;
    logic [ROW_W-1:0]  lmask_c;
    logic [ROW_W-1:0]  ldat_c;
    logic              lane_go_c;

    always_comb begin
        we        = '0;
        idx       = '0;
        mask      = '0;
        wdat      = '0;
        row_c     = '0;
        slot_c    = '0;
        pos_c     = '0;
        k_c       = '0;
        fld_c     = '0;
        lmask_c   = '0;
        ldat_c    = '0;
        lane_go_c = 1'b0;
        case (aspect)
            ASP_X18: begin
                // one row pair, low half in bank 0, high half in bank 1
                idx     = addr[IDX_W-1:0];
                we      = {2{en}};
                mask    = '1;
                wdat[0] = data[ROW_W-1:0];
                wdat[1] = data[DATA_W-1:ROW_W];
            end
            ASP_X9: begin
                row_c     = addr[ROW_AW-1:0];
                lmask_c   = '1;
                ldat_c    = data[ROW_W-1:0];
                lane_go_c = 1'b1;
            end
            ASP_X1, ASP_X2, ASP_X4: begin
                k_c       = aspect[1:0];
                row_c     = ROW_AW'(addr >> (SEL_W - int'(k_c)));
                slot_c    = addr[SEL_W-1:0] & SEL_W'((1 << (SEL_W - int'(k_c))) - 1);
                pos_c     = slot_c << k_c;
                fld_c     = BYTE_W'((1 << (1 << k_c)) - 1);
                lmask_c   = {1'b0, fld_c << pos_c};
                ldat_c    = {1'b0, (data[BYTE_W-1:0] & fld_c) << pos_c};
                lane_go_c = 1'b1;
            end
            default: begin
                // invalid code: no bank enabled
            end
        endcase
        if (lane_go_c) begin
            idx             = row_c[ROW_AW-1:1];
            we[row_c[0]]    = en;
            mask[row_c[0]]  = lmask_c;
            wdat[row_c[0]]  = ldat_c;
        end
    end

endmodule

// File: rtl/mixw_rlane.sv
module mixw_rlane
    import mixw_pkg::*;
#(
    parameter int ROWS   = 512,
    parameter int ROW_W  = 9,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 18,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int IDX_W  = ROW_AW - 1
) (
    input  logic [2:0]            aspect,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0][ROW_W-1:0] raw,
    output logic [IDX_W-1:0]      idx,
    output logic [DATA_W-1:0]     dout
);

    localparam int BYTE_W = ROW_W - 1;
    localparam int SEL_W  = $clog2(BYTE_W);

    logic [ROW_AW-1:0] row_c;
    logic [SEL_W-1:0]  slot_c;
    logic [SEL_W-1:0]  pos_c;
    logic [1:0]        k_c;
    logic [BYTE_W-1:0] fld_c;
    logic [ROW_W-1:0]  lane_c;
    logic [BYTE_W-1:0] byte_c;

    always_comb begin
        idx    = '0;
        dout   = '0;
        row_c  = '0;
        slot_c = '0;
        pos_c  = '0;
        k_c    = '0;
        fld_c  = '0;
        lane_c = '0;
        byte_c = '0;
        case (aspect)
            ASP_X18: begin
                idx  = addr[IDX_W-1:0];
                dout = {raw[1], raw[0]};
            end
            ASP_X9: begin
                row_c  = addr[ROW_AW-1:0];
                idx    = row_c[ROW_AW-1:1];
                lane_c = raw[row_c[0]];
                dout   = DATA_W'(lane_c);
            end
            ASP_X1, ASP_X2, ASP_X4: begin
                k_c    = aspect[1:0];
                row_c  = ROW_AW'(addr >> (SEL_W - int'(k_c)));
                slot_c = addr[SEL_W-1:0] & SEL_W'((1 << (SEL_W - int'(k_c))) - 1);
                pos_c  = slot_c << k_c;
                fld_c  = BYTE_W'((1 << (1 << k_c)) - 1);
                idx    = row_c[ROW_AW-1:1];
                lane_c = raw[row_c[0]];
                byte_c = (lane_c[BYTE_W-1:0] >> pos_c) & fld_c;
                dout   = DATA_W'(byte_c);
            end
            default: begin
                // invalid code reads nothing
            end
        endcase
    end

endmodule

// File: rtl/mixw_dpram.sv
module mixw_dpram
    import mixw_pkg::*;
#(
    parameter int ROWS   = 512,
    parameter int ROW_W  = 9,
    parameter int ADDR_W = $clog2(ROWS * (ROW_W - 1)),
    parameter int DATA_W = 2 * ROW_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_aspect,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [2:0]        rd_aspect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              aspect_clash
);

    localparam int ROW_AW = $clog2(ROWS);
    localparam int IDX_W  = ROW_AW - 1;
    localparam int BANKS  = 2;
    localparam int DEPTH  = ROWS / BANKS;

    typedef struct packed {
        logic [2:0] aspect;
    } wr_st_t;

    typedef struct packed {
        logic [2:0]        aspect;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    localparam wr_st_t WR_RST = '{aspect: ASP_X18};
    localparam rd_st_t RD_RST = '{aspect: ASP_X18, data: '0};

    wr_st_t w_d, w_q;
    rd_st_t r_d, r_q;

    logic [BANKS-1:0]            map_we;
    logic [IDX_W-1:0]            map_idx;
    logic [BANKS-1:0][ROW_W-1:0] map_mask;
    logic [BANKS-1:0][ROW_W-1:0] map_dat;
    logic [IDX_W-1:0]            sel_idx;
    logic [BANKS-1:0][ROW_W-1:0] bank_raw;
    logic [DATA_W-1:0]           sel_dout;

    // ---------------- write side ----------------
    always_comb begin
        w_d = w_q;
        if (!wr_en) begin
            w_d.aspect = wr_aspect;
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            w_q <= WR_RST;
        end else begin
            w_q <= w_d;
        end
    end

    mixw_wlane #(
        .ROWS   (ROWS),
        .ROW_W  (ROW_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wlane (
        .en     (wr_en),
        .aspect (w_q.aspect),
        .addr   (wr_addr),
        .data   (wr_data),
        .we     (map_we),
        .idx    (map_idx),
        .mask   (map_mask),
        .wdat   (map_dat)
    );

    // ---------------- storage ----------------
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        mixw_bank #(
            .DEPTH (DEPTH),
            .ROW_W (ROW_W)
        ) u_bank (
            .wr_clk (wr_clk),
            .we     (map_we[g]),
            .widx   (map_idx),
            .wmask  (map_mask[g]),
            .wdat   (map_dat[g]),
            .ridx   (sel_idx),
            .rraw   (bank_raw[g])
        );
    end

    // ---------------- read side ----------------
    mixw_rlane #(
        .ROWS   (ROWS),
        .ROW_W  (ROW_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rlane (
        .aspect (r_q.aspect),
        .addr   (rd_addr),
        .raw    (bank_raw),
        .idx    (sel_idx),
        .dout   (sel_dout)
    );

    assign aspect_clash = asp_clash(w_q.aspect, r_q.aspect);

    always_comb begin
        r_d = r_q;
        if (!rd_en) begin
            r_d.aspect = rd_aspect;
        end else begin
            r_d.data = aspect_clash ? '0 : sel_dout;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            r_q <= RD_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.data;

    // ---------------- assertions ----------------
    AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> $stable(rd_data)); // R6

    AST_CLASH_READS_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && aspect_clash) |=> (rd_data == '0)); // R9

    AST_NARROW_ZEXT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && asp_narrow(r_q.aspect)) |=> ((rd_data >> (1 << r_q.aspect[1:0])) == '0)); // R5

    AST_X9_ZEXT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && (r_q.aspect == ASP_X9)) |=> (rd_data[DATA_W-1:ROW_W] == '0)); // R5

    AST_RD_CODE_HELD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && $past(rd_en)) |-> $stable(rd_aspect)); // R8

    AST_WR_CODE_HELD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && $past(wr_en)) |-> $stable(wr_aspect)); // R8

    AST_ONE_BANK: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && asp_valid(w_q.aspect) && (w_q.aspect != ASP_X18)) |-> $onehot(map_we)); // R3

    AST_PARITY_KEPT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && asp_narrow(w_q.aspect)) |-> (!map_mask[0][ROW_W-1] && !map_mask[1][ROW_W-1])); // R4

    AST_BAD_CODE_NOWRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !asp_valid(w_q.aspect)) |-> (map_we == '0)); // R10

endmodule

// File: tb/mixw_dpram_tb.sv
module mixw_dpram_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [2:0]  wr_aspect, rd_aspect;
    logic [11:0] wr_addr, rd_addr;
    logic [17:0] wr_data;
    logic [17:0] rd_data;
    logic        aspect_clash;

    always #4 clk = ~clk; // 125 MHz

    mixw_dpram u_dut (
        .wr_clk       (clk),
        .wr_rst_n     (rst_n),
        .wr_en        (wr_en),
        .wr_aspect    (wr_aspect),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_clk       (clk),
        .rd_rst_n     (rst_n),
        .rd_en        (rd_en),
        .rd_aspect    (rd_aspect),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .aspect_clash (aspect_clash)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_on = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural model: flat bit array, bit (row*9 + b)
    logic        ref_mem [0:4607];
    int          m_wa, m_ra;
    logic [17:0] exp_rd;
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic bit ref_bad(int wa, int ra);
        return (wa > 4) || (ra > 4) || ((wa >= 3) != (ra >= 3));
    endfunction

    function automatic logic [17:0] ref_read(int code, int a);
        logic [17:0] v = '0;
        if (code == 4) begin
            a = a % 256;
            for (int i = 0; i < 18; i++) v[i] = ref_mem[18*a + i];
        end else if (code == 3) begin
            a = a % 512;
            for (int i = 0; i < 9; i++) v[i] = ref_mem[9*a + i];
        end else begin
            int w   = 1 << code;
            int per = 8 / w;
            a = a % (512 * per);
            for (int i = 0; i < w; i++) v[i] = ref_mem[9*(a/per) + (a%per)*w + i];
        end
        return v;
    endfunction

    task automatic ref_write(int code, int a, logic [17:0] d);
        if (code == 4) begin
            a = a % 256;
            for (int i = 0; i < 18; i++) ref_mem[18*a + i] = d[i];
        end else if (code == 3) begin
            a = a % 512;
            for (int i = 0; i < 9; i++) ref_mem[9*a + i] = d[i];
        end else begin
            int w   = 1 << code;
            int per = 8 / w;
            a = a % (512 * per);
            for (int i = 0; i < w; i++) ref_mem[9*(a/per) + (a%per)*w + i] = d[i];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wa   = 4;
            m_ra   = 4;
            exp_rd = '0;
        end else begin
            if (rd_en) exp_rd = ref_bad(m_wa, m_ra) ? 18'd0 : ref_read(m_ra, int'(rd_addr));
            if (wr_en && m_wa <= 4) ref_write(m_wa, int'(wr_addr), wr_data);
            if (!wr_en) m_wa = int'(wr_aspect);
            if (!rd_en) m_ra = int'(rd_aspect);
        end
    end

    task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            check(cur_req, rd_data, exp_rd);
            check("R9 clash flag", {17'd0, aspect_clash}, {17'd0, ref_bad(m_wa, m_ra)});
        end
    end

    function automatic logic [31:0] step(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic idle_codes(logic [2:0] wa, logic [2:0] ra);
        wr_en = 0; rd_en = 0; wr_aspect = wa; rd_aspect = ra;
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [17:0] d);
        wr_en = 1; wr_addr = 12'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a);
        rd_en = 1; rd_addr = 12'(a);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wr_rd(int wa, logic [17:0] d, int ra);
        wr_en = 1; wr_addr = 12'(wa); wr_data = d;
        rd_en = 1; rd_addr = 12'(ra);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hang, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0;
        wr_aspect = 3'd4; rd_aspect = 3'd4;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset rd_data", rd_data, 18'd0);
        check("R11 reset clash", {17'd0, aspect_clash}, 18'd0);
        chk_on = 1;

        // R1: fill every x18 word, read all back
        cur_req = "R1";
        for (int a = 0; a < 256; a++) begin
            lfsr = step(lfsr);
            wr(a, lfsr[17:0]);
        end
        for (int a = 0; a < 256; a++) rd(a);

        // R3: cross mapping between x9 and x18
        cur_req = "R3";
        idle_codes(3'd3, 3'd4);
        for (int i = 0; i < 20; i++) begin
            lfsr = step(lfsr);
            wr(int'(lfsr[11:0]), lfsr[29:12]);
        end
        wr(511, 18'h1A5);
        for (int i = 0; i < 20; i++) begin
            lfsr = step(lfsr);
            rd(int'(lfsr[11:0]));
        end
        rd(255);
        idle_codes(3'd4, 3'd3);
        for (int a = 0; a < 16; a++) rd(a);
        rd(511);

        // R3: x4 write read as x1 and x2
        cur_req = "R3 R5";
        idle_codes(3'd2, 3'd0);
        wr(0, 18'h0000A);
        wr(1, 18'h3FFF5);
        for (int a = 0; a < 8; a++) rd(a);
        idle_codes(3'd2, 3'd1);
        for (int a = 0; a < 4; a++) rd(a);

        // R2 R3 R5: every narrow pair
        cur_req = "R2 R3 R5";
        for (int wa = 0; wa < 3; wa++) begin
            for (int ra = 0; ra < 3; ra++) begin
                idle_codes(3'(wa), 3'(ra));
                wr(4095, 18'h3FFFF);
                for (int i = 0; i < 12; i++) begin
                    lfsr = step(lfsr);
                    wr(int'(lfsr[11:0]) % 64, lfsr[29:12]);
                end
                rd(4095);
                for (int i = 0; i < 12; i++) begin
                    lfsr = step(lfsr);
                    rd(int'(lfsr[11:0]) % 64);
                end
            end
        end

        // R2 R3: every wide pair
        cur_req = "R2 R3";
        for (int wa = 3; wa < 5; wa++) begin
            for (int ra = 3; ra < 5; ra++) begin
                idle_codes(3'(wa), 3'(ra));
                for (int i = 0; i < 8; i++) begin
                    lfsr = step(lfsr);
                    wr(int'(lfsr[11:0]) % 32, lfsr[29:12]);
                end
                for (int i = 0; i < 8; i++) begin
                    lfsr = step(lfsr);
                    rd(int'(lfsr[11:0]) % 32);
                end
            end
        end

        // R4: parity bit survives narrow writes
        cur_req = "R4";
        idle_codes(3'd3, 3'd3);
        wr(5, 18'h1FF);
        rd(5);
        idle_codes(3'd0, 3'd0);
        for (int a = 40; a < 48; a++) wr(a, 18'd0);
        for (int a = 40; a < 48; a++) rd(a);
        idle_codes(3'd3, 3'd3);
        rd(5);

        // R6: hold while read enable low
        cur_req = "R6";
        rd(5);
        for (int i = 0; i < 5; i++) begin
            rd_addr = 12'(i * 3);
            @(negedge clk);
        end

        // R7: same location, same edge
        cur_req = "R7";
        wr(7, 18'h055);
        wr_rd(7, 18'h1AA, 7);
        rd(7);
        idle_codes(3'd4, 3'd4);
        wr_rd(3, 18'h2AAAA, 3);
        rd(3);

        // R8: code offered with the rising enable is not taken
        cur_req = "R8";
        idle_codes(3'd2, 3'd2);
        rd_en = 1; rd_addr = 12'd1; rd_aspect = 3'd0;
        @(negedge clk);
        rd_addr = 12'd2;
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
        rd(1);
        rd(9);
        wr_en = 1; wr_addr = 12'd6; wr_data = 18'h00C; wr_aspect = 3'd0;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        idle_codes(3'd2, 3'd2);
        rd(6);
        rd(7);

        // R9: class mix and invalid codes
        cur_req = "R9";
        idle_codes(3'd3, 3'd2);
        rd(0);
        rd(1);
        wr(3, 18'h0F3);
        idle_codes(3'd4, 3'd1);
        rd(2);
        idle_codes(3'd3, 3'd3);
        rd(3);
        idle_codes(3'd3, 3'd6);
        rd(3);

        // R10: invalid write code stores nothing
        cur_req = "R10";
        idle_codes(3'd5, 3'd3);
        wr(9, 18'h0AB);
        wr(10, 18'h154);
        idle_codes(3'd3, 3'd3);
        rd(9);
        rd(10);
        idle_codes(3'd7, 3'd4);
        wr(20, 18'h3C3C3);
        idle_codes(3'd4, 3'd4);
        rd(20);
        @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

endmodule